// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a synchronous I2C target. It runs on a fast system clock and oversamples the bus lines. SCL and SDA each pass through a multi-flop synchronizer. Start, stop and clock edges are then found by comparing the synchronized level with its previous value. The block never drives a line high: it only asserts an enable that pulls SCL or SDA low, and the pad ring turns that into an open-drain output.

After a start condition the target shifts in a 7-bit address followed by a direction bit. When the address matches its fixed target address, the target acknowledges. In a write transfer, every byte received is acknowledged and passed to the local side as a one-cycle write strobe. In a read transfer, the target raises a read request and holds SCL low until the local side returns a byte with a valid pulse. It then shifts that byte out. The master's ACK asks for another byte, and its NACK ends the transfer.

A repeated start restarts address reception at any point. A stop returns the block to idle at any point, even in the middle of a byte.

Top module: `i2c_stretch_target`

## Requirements
- R1: While reset is asserted and right after it, `scl_oe`, `sda_oe`, `wr_strobe` and `rd_req` are all low.
- R2: A start is SDA falling while SCL is high, and it always begins address reception. A stop is SDA rising while SCL is high, and it releases both lines and drops `rd_req` on the next cycle.
- R3: The first byte after a start is the address in bits 7..1, MSB first, with the direction in bit 0 (0 means the master writes, 1 means the master reads). When bits 7..1 equal `TGT_ADDR`, SDA is pulled low during the ninth clock.
- R4: When the address does not match, the target does not pull SDA or SCL at any point until the next start. The master therefore sees a NACK and reads all-ones.
- R5: In a write, each data byte is received MSB first and acknowledged with SDA low in its ninth clock. `wr_strobe` is high for exactly one cycle with the byte on `wr_data`, in bus order.
- R6: In a read, `rd_req` rises after the ACK clock and holds SCL low until `rd_valid` arrives. The `rd_data` byte is then shifted out MSB first.
- R7: SCL is held low for at least as many cycles as the local side delays `rd_valid`. It is released exactly one cycle after the byte is loaded onto SDA.
- R8: A master ACK after a read byte raises `rd_req` again. A master NACK releases SDA and SCL, and `rd_req` stays low.
- R9: The target changes its SDA enable only while the synchronized SCL is low.
- R10: A stop or start in the middle of a byte abandons that byte. No strobe is produced for it, and the next transfer works normally.
- R11: A write followed by a repeated start and a read, with no stop between them, delivers the written byte and then the read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_oe | output | 1 | High pulls SCL low (clock stretching) |
| sda_oe | output | 1 | High pulls SDA low |
| wr_strobe | output | 1 | One-cycle pulse when a written byte is accepted |
| wr_data | output | 8 | Byte received from the master |
| rd_req | output | 1 | High while the target waits for a byte to send |
| rd_valid | input | 1 | Pulse: `rd_data` holds the byte to send |
| rd_data | input | 8 | Byte to shift out to the master |

## Verification
The bench builds the target with `TGT_ADDR` = 7'h52 and two synchronizer stages. It runs SCL at one twentieth of the system clock, well above the minimum ratio of 8, so the three-cycle path from an SCL edge to a registered output stays inside each low phase. Against this address, the vector table mixes matching and neighbouring addresses (7'h53, 7'h12) to exercise both the ACK path and the silent path. The local responder delays its answer by 0, 3 or 40 cycles; the 40-cycle delay makes the stretch outlast a whole SCL half period.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ADDR     = 4'd1,
        ST_ADDR_ACK = 4'd2,
        ST_WR_DATA  = 4'd3,
        ST_WR_ACK   = 4'd4,
        ST_RD_WAIT  = 4'd5,
        ST_RD_SETUP = 4'd6,
        ST_RD_DATA  = 4'd7,
        ST_RD_ACK   = 4'd8
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e              state;
        logic [CNT_W-1:0]        bit_cnt;
        logic                    got_byte;
        logic [BYTE_W-1:0]       shreg;
        logic                    rw;
        logic                    mack;
        logic                    sda_oe;
        logic                    scl_oe;
        logic                    wr_stb;
        logic [BYTE_W-1:0]       wr_byte;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_p
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], line_i};
    end

    // An idle bus floats high, so the pipe resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign line_s = pipe_q[STAGES-1];
    assign line_p = pipe_q[STAGES];
endmodule

// File: rtl/i2c_tgt_cond_detect.sv
module i2c_tgt_cond_detect (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_s & scl_p;
        scl_rise      = scl_s & ~scl_p;
        scl_fall      = ~scl_s & scl_p;
        start_det     = scl_held_high & sda_p & ~sda_s;
        stop_det      = scl_held_high & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_regs_t d, q;

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        if (stop_det) begin
            d.state    = ST_IDLE;
            d.sda_oe   = 1'b0;
            d.scl_oe   = 1'b0;
            d.bit_cnt  = '0;
            d.got_byte = 1'b0;
        end else if (start_det) begin
            d.state    = ST_ADDR;
            d.sda_oe   = 1'b0;
            d.scl_oe   = 1'b0;
            d.bit_cnt  = '0;
            d.got_byte = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        if (q.bit_cnt == CNT_LAST) d.got_byte = 1'b1;
                        else                       d.bit_cnt  = q.bit_cnt + 1'b1;
                    end else if (scl_fall && q.got_byte) begin
                        d.got_byte = 1'b0;
                        d.bit_cnt  = '0;
                        if (q.shreg[BYTE_W-1 -: ADDR_W] == TGT_ADDR) begin
                            d.state  = ST_ADDR_ACK;
                            d.sda_oe = 1'b1;
                            d.rw     = q.shreg[0];
                        end else begin
                            d.state  = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        if (q.rw) begin
                            d.state  = ST_RD_WAIT;
                            d.scl_oe = 1'b1;
                        end else begin
                            d.state  = ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        if (q.bit_cnt == CNT_LAST) d.got_byte = 1'b1;
                        else                       d.bit_cnt  = q.bit_cnt + 1'b1;
                    end else if (scl_fall && q.got_byte) begin
                        d.got_byte = 1'b0;
                        d.bit_cnt  = '0;
                        d.wr_stb   = 1'b1;
                        d.wr_byte  = q.shreg;
                        d.sda_oe   = 1'b1;
                        d.state    = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.state  = ST_WR_DATA;
                    end
                end
                ST_RD_WAIT: begin
                    if (rd_valid) begin
                        d.shreg   = rd_data;
                        d.sda_oe  = ~rd_data[BYTE_W-1];
                        d.bit_cnt = '0;
                        d.state   = ST_RD_SETUP;
                    end
                end
                ST_RD_SETUP: begin
                    d.scl_oe = 1'b0;
                    d.state  = ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (q.bit_cnt == CNT_LAST) begin
                            d.sda_oe = 1'b0;
                            d.state  = ST_RD_ACK;
                        end else begin
                            d.shreg   = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_oe  = ~q.shreg[BYTE_W-2];
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state  = ST_RD_WAIT;
                            d.scl_oe = 1'b1;
                        end else begin
                            d.state  = ST_IDLE;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
    assign wr_strobe = q.wr_stb;
    assign wr_data   = q.wr_byte;
    assign rd_req    = (q.state == ST_RD_WAIT);

    // R9
    sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_oe) |-> !scl_s);

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |=> !q.wr_stb);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !start_det && !stop_det) |=> (rd_req && q.scl_oe));

    // R7
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl_oe && !rd_req) |-> $past(rd_valid));

    // R7
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl_oe && !rd_req) |=> !q.scl_oe);

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!q.sda_oe && !q.scl_oe && !rd_req));
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
    parameter logic [i2c_tgt_pkg::ADDR_W-1:0] TGT_ADDR    = 7'h52,
    parameter int                             SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_i,
    input  logic                           sda_i,
    output logic                           scl_oe,
    output logic                           sda_oe,
    output logic                           wr_strobe,
    output logic [i2c_tgt_pkg::BYTE_W-1:0] wr_data,
    output logic                           rd_req,
    input  logic                           rd_valid,
    input  logic [i2c_tgt_pkg::BYTE_W-1:0] rd_data
);
    localparam int NLINES  = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [NLINES-1:0] raw_lines, lvl_s, lvl_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines[IDX_SCL] = scl_i;
    assign raw_lines[IDX_SDA] = sda_i;

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_s (lvl_s[g]),
            .line_p (lvl_p[g])
        );
    end

    i2c_tgt_cond_detect u_cond (
        .scl_s     (lvl_s[IDX_SCL]),
        .scl_p     (lvl_p[IDX_SCL]),
        .sda_s     (lvl_s[IDX_SDA]),
        .sda_p     (lvl_p[IDX_SDA]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lvl_s[IDX_SCL]),
        .sda_s     (lvl_s[IDX_SDA]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_req    (rd_req)
    );
endmodule

// File: tb/i2c_stretch_target_tb_top.sv
module i2c_stretch_target_tb_top;
    localparam logic [6:0] TGT = 7'h52;
    localparam int Q  = 5;
    localparam int WD = 100000;
    localparam int NV = 8;
    // {rw, addr, data, responder delay}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 7'h52, 8'hA5, 8'd0},
        {1'b0, 7'h53, 8'h3C, 8'd0},
        {1'b1, 7'h52, 8'hC3, 8'd0},
        {1'b0, 7'h52, 8'h00, 8'd0},
        {1'b1, 7'h52, 8'hFF, 8'd40},
        {1'b0, 7'h12, 8'hFF, 8'd0},
        {1'b1, 7'h52, 8'h81, 8'd3},
        {1'b0, 7'h52, 8'h7E, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe, wr_strobe, rd_req;
    logic [7:0] wr_data;
    logic rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_stretch_target #(.TGT_ADDR(TGT), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // monitors
    logic [7:0] cap [64];
    int cap_n = 0, sda_cnt = 0, str_cnt = 0, req_rises = 0, r9_viol = 0;
    logic req_prev = 1'b0, soe_prev = 1'b0;
    always @(negedge clk) begin
        if (wr_strobe) begin cap[cap_n[5:0]] = wr_data; cap_n++; end
        if (sda_oe) sda_cnt++;
        if (scl_oe) str_cnt++;
        if (rd_req && !req_prev) req_rises++;
        if (sda_oe !== soe_prev && scl_bus) r9_viol++;
        req_prev = rd_req;
        soe_prev = sda_oe;
    end

    // local read responder
    logic [7:0] resp_mem [64];
    int rsp_ptr = 0;
    int resp_delay = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && !rd_valid) begin
                repeat (resp_delay) @(negedge clk);
                rd_data  = resp_mem[rsp_ptr[5:0]];
                rsp_ptr++;
                rd_valid = 1'b1;
                @(negedge clk);
                rd_valid = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait (scl_bus); wait_clk(Q);
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b1; wait (scl_bus); wait_clk(Q);
        m_sda = 1'b1; wait_clk(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; wait_clk(Q);
        m_scl = 1'b1; wait (scl_bus); wait_clk(Q);
        s = sda_bus; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~give_ack, s);
    endtask

    initial begin
        logic ack, ack2;
        logic [7:0] rd;
        int base_cap, base_sda, base_str, base_req, p;

        wait_clk(3);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1", "line enables in reset", {scl_oe, sda_oe}, 0);
        check(!wr_strobe && !rd_req, "R1", "handshake in reset", {wr_strobe, rd_req}, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(!scl_oe && !sda_oe && !rd_req, "R1", "outputs after reset",
              {scl_oe, sda_oe, rd_req}, 0);

        // table-driven single-byte transfers
        for (int i = 0; i < NV; i++) begin
            logic       rw;
            logic [6:0] a;
            logic [7:0] dv;
            int         dl;
            rw = VEC[i][23]; a = VEC[i][22:16]; dv = VEC[i][15:8]; dl = int'(VEC[i][7:0]);
            base_cap = cap_n; base_sda = sda_cnt; base_str = str_cnt; base_req = req_rises;
            resp_mem[rsp_ptr[5:0]] = dv;
            resp_delay = dl;
            bus_start();
            write_byte({a, rw}, ack);
            check(ack == (a == TGT), "R3", "address ack", ack, (a == TGT));
            if (!rw) begin
                write_byte(dv, ack2);
                bus_stop();
                if (a == TGT) begin
                    check(ack2, "R5", "data ack", ack2, 1);
                    check(cap_n == base_cap + 1 && cap[base_cap[5:0]] == dv, "R5",
                          "write strobe byte", cap[base_cap[5:0]], dv);
                end else begin
                    check(!ack2, "R4", "data nack on mismatch", ack2, 0);
                    check(sda_cnt == base_sda && cap_n == base_cap, "R4",
                          "no drive or strobe on mismatch", sda_cnt - base_sda, 0);
                end
            end else begin
                read_byte(1'b0, rd);
                bus_stop();
                check(rd == dv, "R6", "read byte", rd, dv);
                check(str_cnt - base_str >= dl, "R7", "stretch cycles", str_cnt - base_str, dl);
                check(req_rises - base_req == 1, "R8", "requests after nack",
                      req_rises - base_req, 1);
            end
            wait_clk(10);
        end

        // R5 multi-byte write order
        base_cap = cap_n;
        bus_start();
        write_byte({TGT, 1'b0}, ack);
        write_byte(8'h01, ack); write_byte(8'h80, ack); write_byte(8'h5C, ack2);
        bus_stop();
        check(cap_n == base_cap + 3 && cap[base_cap[5:0]] == 8'h01 &&
              cap[(base_cap + 1) & 63] == 8'h80 && cap[(base_cap + 2) & 63] == 8'h5C,
              "R5", "three-byte write order", cap_n - base_cap, 3);
        wait_clk(10);

        // R6/R8 multi-byte read, ACK ACK NACK
        p = rsp_ptr;
        resp_mem[p & 63] = 8'h11; resp_mem[(p + 1) & 63] = 8'h22; resp_mem[(p + 2) & 63] = 8'h33;
        resp_delay = 2;
        base_req = req_rises;
        bus_start();
        write_byte({TGT, 1'b1}, ack);
        begin
            logic [7:0] b0, b1, b2;
            read_byte(1'b1, b0); read_byte(1'b1, b1); read_byte(1'b0, b2);
            check({b0, b1, b2} == 24'h112233, "R6", "three-byte read order", {b0, b1, b2}, 24'h112233);
        end
        wait_clk(40);
        check(!rd_req && !sda_oe && !scl_oe, "R8", "released after nack",
              {rd_req, sda_oe, scl_oe}, 0);
        check(req_rises - base_req == 3, "R8", "request per acked byte", req_rises - base_req, 3);
        bus_stop();
        wait_clk(10);

        // R10 stop in the middle of a data byte
        base_cap = cap_n;
        bus_start();
        write_byte({TGT, 1'b0}, ack);
        clk_bit(1'b1, ack2); clk_bit(1'b0, ack2); clk_bit(1'b1, ack2); clk_bit(1'b1, ack2);
        bus_stop();
        wait_clk(10);
        check(cap_n == base_cap, "R10", "no strobe for cut byte", cap_n - base_cap, 0);
        bus_start();
        write_byte({TGT, 1'b0}, ack);
        write_byte(8'hA2, ack2);
        bus_stop();
        check(cap_n == base_cap + 1 && cap[base_cap[5:0]] == 8'hA2, "R10",
              "write after abort", cap[base_cap[5:0]], 8'hA2);
        wait_clk(10);

        // R2 start in the middle of the address
        base_cap = cap_n;
        bus_start();
        clk_bit(1'b1, ack2); clk_bit(1'b0, ack2); clk_bit(1'b1, ack2);
        bus_start();
        write_byte({TGT, 1'b0}, ack);
        check(ack, "R2", "address ack after restart", ack, 1);
        write_byte(8'h5A, ack2);
        bus_stop();
        check(cap_n == base_cap + 1 && cap[base_cap[5:0]] == 8'h5A, "R10",
              "byte after mid-address start", cap[base_cap[5:0]], 8'h5A);
        wait_clk(10);

        // R11 write, repeated start, read
        base_cap = cap_n;
        resp_mem[rsp_ptr[5:0]] = 8'h99;
        resp_delay = 5;
        bus_start();
        write_byte({TGT, 1'b0}, ack);
        write_byte(8'h11, ack2);
        bus_start();
        write_byte({TGT, 1'b1}, ack);
        check(ack, "R11", "read address ack after repeated start", ack, 1);
        read_byte(1'b0, rd);
        bus_stop();
        check(cap_n == base_cap + 1 && cap[base_cap[5:0]] == 8'h11, "R11",
              "written byte before restart", cap[base_cap[5:0]], 8'h11);
        check(rd == 8'h99, "R11", "read byte after restart", rd, 8'h99);
        wait_clk(10);

        // R4 mismatched read: no stretch, all-ones
        base_str = str_cnt; base_req = req_rises; base_sda = sda_cnt;
        bus_start();
        write_byte({7'h10, 1'b1}, ack);
        read_byte(1'b0, rd);
        bus_stop();
        check(!ack && rd == 8'hFF, "R4", "mismatched read data", rd, 8'hFF);
        check(str_cnt == base_str && req_rises == base_req && sda_cnt == base_sda, "R4",
              "no stretch or drive on mismatch", str_cnt - base_str, 0);

        // R9 SDA enable changes only while SCL low
        check(r9_viol == 0, "R9", "SDA change while SCL high", r9_viol, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule